// File: doc/BRIEF.md
# Circular Descriptor Queue Reader

This block is the DMA-side reader of a ring of 32-bit descriptor entries that a host places in its own memory. The host programs where the ring lives, as a 32-bit base split across two 16-bit words. It also programs how far the ring reaches, as an end offset relative to that base. It then publishes new entries by moving a write pointer. The block owns a read pointer. It fetches one dword at a time from base plus read pointer, and the fetch goes through a simple request/valid memory port.

Fetching starts only once the host has set a transmit enable bit, and only while the ring is not empty. The ring is empty when the read pointer equals the write pointer. When a fetch returns, the read pointer steps by four bytes. It goes back to zero only when the stepped value lies beyond the end offset. The returned dword is handed on through a descriptor output. A sticky status bit records the fetch and, when enabled, drives an interrupt line.

The read pointer is a byte offset of `PTR_W` bits. The default of 18 bits covers a ring of up to 65536 entries.

Top module: `pend_queue_fetch`

## Requirements
- R1: After reset the read pointer reads 0, the status bit is 0, and mem_req, desc_valid and irq are low.
- R2: No fetch request is issued while the enable bit (bit 0 at register offset 040h) is 0. Clearing it while a fetch is outstanding lets that fetch complete but starts no new one.
- R3: No fetch request is issued while the read pointer equals the write pointer.
- R4: Each fetch request carries mem_addr = {base upper word, base lower word} + read pointer.
- R5: At most one fetch is outstanding. mem_req is a one-cycle pulse, and no new pulse comes until mem_rvalid has returned.
- R6: In the cycle mem_rvalid is seen, the read pointer is loaded with itself plus 4 if that sum is not greater than the end offset.
- R7: If the read pointer plus 4 is greater than the end offset, the read pointer is loaded with 0. A sum equal to the end offset does not wrap.
- R8: One cycle after mem_rvalid, desc_valid is high for exactly one cycle and desc_data holds the returned mem_rdata.
- R9: Each completed fetch sets the status bit (bit 0 at offset 044h). It stays set until the host writes 1 to that bit. Writing 0 leaves it unchanged.
- R10: irq is high exactly when the status bit and the interrupt enable (bit 0 at offset 048h) are both 1.
- R11: The registers read back at their offsets: base lower word 800h, base upper word 804h, end offset 808h, write pointer 80Ch, read pointer 810h (read-only).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | One-cycle fetch request |
| mem_addr | output | 32 | Fetch address, valid with mem_req |
| mem_rvalid | input | 1 | Fetch data returned |
| mem_rdata | input | 32 | Returned dword |
| desc_valid | output | 1 | Descriptor output strobe |
| desc_data | output | 32 | Fetched descriptor |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the clock edge that samples it. A fetch request therefore appears one cycle after the edge at which the enable, the pointers and the not-busy state allow it. desc_valid, the new read pointer and the status bit (and so irq) all change one edge after mem_rvalid is sampled. The bench model advances at each rising edge from the same inputs. It compares every output at the following falling edge, so each expected value is checked in the exact cycle it is due. The memory responder's latency is varied between 1 and 8 cycles to test the single-outstanding rule.

// File: rtl/pend_queue_fetch.sv
module pend_queue_fetch #(
  parameter int PTR_W = 18,
  parameter int RA_W  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            mem_req,
  output logic [31:0]     mem_addr,
  input  logic            mem_rvalid,
  input  logic [31:0]     mem_rdata,
  output logic            desc_valid,
  output logic [31:0]     desc_data,
  output logic            irq
);
  localparam logic [RA_W-1:0] A_CTL  = RA_W'('h040);
  localparam logic [RA_W-1:0] A_STAT = RA_W'('h044);
  localparam logic [RA_W-1:0] A_IEN  = RA_W'('h048);
  localparam logic [RA_W-1:0] A_BLO  = RA_W'('h800);
  localparam logic [RA_W-1:0] A_BHI  = RA_W'('h804);
  localparam logic [RA_W-1:0] A_END  = RA_W'('h808);
  localparam logic [RA_W-1:0] A_WP   = RA_W'('h80C);
  localparam logic [RA_W-1:0] A_RP   = RA_W'('h810);

  logic [15:0]      base_lo, base_hi;
  logic [PTR_W-1:0] end_off, wr_ptr, rd_ptr;
  logic             dma_en, int_en, stat, busy;

  wire [31:0]      base  = {base_hi, base_lo};
  wire [PTR_W:0]   step  = {1'b0, rd_ptr} + (PTR_W+1)'(4);
  wire             past  = step > {1'b0, end_off};
  wire [PTR_W-1:0] nxt   = past ? '0 : step[PTR_W-1:0];
  wire             go    = dma_en && !busy && (rd_ptr != wr_ptr);
  wire             done  = mem_rvalid && busy;
  wire             clr   = reg_we && reg_addr == A_STAT && reg_wdata[0];

  assign irq = stat & int_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_lo <= '0; base_hi <= '0; end_off <= '0; wr_ptr <= '0; rd_ptr <= '0;
      dma_en <= 1'b0; int_en <= 1'b0; stat <= 1'b0; busy <= 1'b0;
      mem_req <= 1'b0; mem_addr <= '0; desc_valid <= 1'b0; desc_data <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          A_CTL:   dma_en  <= reg_wdata[0];
          A_IEN:   int_en  <= reg_wdata[0];
          A_BLO:   base_lo <= reg_wdata[15:0];
          A_BHI:   base_hi <= reg_wdata[15:0];
          A_END:   end_off <= reg_wdata[PTR_W-1:0];
          A_WP:    wr_ptr  <= reg_wdata[PTR_W-1:0];
          default: ;
        endcase
      end
      mem_req    <= go;
      desc_valid <= done;
      if (go) begin
        mem_addr <= base + 32'(rd_ptr);
        busy     <= 1'b1;
      end
      if (done) begin
        rd_ptr    <= nxt;
        busy      <= 1'b0;
        desc_data <= mem_rdata;
        stat      <= 1'b1;
      end else if (clr) begin
        stat <= 1'b0;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTL:   reg_rdata = {31'd0, dma_en};
      A_STAT:  reg_rdata = {31'd0, stat};
      A_IEN:   reg_rdata = {31'd0, int_en};
      A_BLO:   reg_rdata = {16'd0, base_lo};
      A_BHI:   reg_rdata = {16'd0, base_hi};
      A_END:   reg_rdata = 32'(end_off);
      A_WP:    reg_rdata = 32'(wr_ptr);
      A_RP:    reg_rdata = 32'(rd_ptr);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pend_queue_fetch_chk.sv
module pend_queue_fetch_chk #(
  parameter int PTR_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_req,
  input logic             mem_rvalid,
  input logic [31:0]      mem_rdata,
  input logic             desc_valid,
  input logic [31:0]      desc_data,
  input logic             irq,
  input logic             en,
  input logic             ie,
  input logic [PTR_W-1:0] rptr,
  input logic [PTR_W-1:0] wptr,
  input logic [PTR_W-1:0] end_off
);
  logic outst;
  always_ff @(posedge clk) begin
    if (!rst_n) outst <= 1'b0;
    else if (mem_req) outst <= 1'b1;
    else if (mem_rvalid) outst <= 1'b0;
  end

  a_r5_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !outst);
  a_r2_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(en));
  a_r3_empty: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(rptr != wptr));
  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rvalid && outst && ({1'b0, rptr} + (PTR_W+1)'(4) <= {1'b0, end_off}))
      |=> rptr == $past(rptr) + PTR_W'(4));
  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rvalid && outst && ({1'b0, rptr} + (PTR_W+1)'(4) > {1'b0, end_off}))
      |=> rptr == '0);
  a_r8_desc: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rvalid && outst) |=> desc_valid && desc_data == $past(mem_rdata));
  a_r10_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rvalid && outst && ie) |=> irq);
endmodule

bind pend_queue_fetch pend_queue_fetch_chk #(.PTR_W(PTR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_rvalid(mem_rvalid),
  .mem_rdata(mem_rdata), .desc_valid(desc_valid), .desc_data(desc_data),
  .irq(irq), .en(dma_en), .ie(int_en), .rptr(rd_ptr), .wptr(wr_ptr),
  .end_off(end_off));

// File: tb/test_pend_queue_fetch.sv
module test_pend_queue_fetch;
  logic clk = 0, rst_n = 0, reg_we = 0, mem_rvalid = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, mem_rdata = '0;
  logic [31:0] reg_rdata, mem_addr, desc_data;
  logic mem_req, desc_valid, irq;
  int total = 0, bad = 0, reqs = 0, lat = 1, cnt = 0;
  logic [31:0] paddr;
  bit fin = 0;

  always #2 clk = ~clk;

  pend_queue_fetch i_pend_queue_fetch (.*);

  // reference model state
  bit m_en, m_ie, m_stat, m_busy, m_req, m_dv;
  int m_base, m_end, m_wp, m_rp;
  logic [31:0] m_addr, m_dd;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_ie = 0; m_stat = 0; m_busy = 0; m_req = 0; m_dv = 0;
      m_base = 0; m_end = 0; m_wp = 0; m_rp = 0; m_addr = 0; m_dd = 0;
    end else begin
      bit iss;
      iss = m_en && !m_busy && (m_rp != m_wp);
      m_dv = 0;
      if (mem_rvalid && m_busy) begin
        m_rp = (m_rp + 4 > m_end) ? 0 : m_rp + 4;
        m_busy = 0; m_dv = 1; m_dd = mem_rdata; m_stat = 1;
      end else if (reg_we && reg_addr == 12'h044 && reg_wdata[0]) m_stat = 0;
      if (reg_we) case (reg_addr)
        12'h040: m_en = reg_wdata[0];
        12'h048: m_ie = reg_wdata[0];
        12'h800: m_base = (m_base & 32'hFFFF0000) | int'(reg_wdata[15:0]);
        12'h804: m_base = (m_base & 32'h0000FFFF) | (int'(reg_wdata[15:0]) << 16);
        12'h808: m_end = int'(reg_wdata[17:0]);
        12'h80C: m_wp = int'(reg_wdata[17:0]);
        default: ;
      endcase
      m_req = iss;
      if (iss) begin m_addr = m_base + m_rp; m_busy = 1; end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(mem_req == m_req, "R2/R3/R5 mem_req", mem_req, m_req);
    if (m_req) chk(mem_addr == m_addr, "R4 mem_addr", mem_addr, m_addr);
    chk(desc_valid == m_dv, "R8 desc_valid", desc_valid, m_dv);
    if (m_dv) chk(desc_data == m_dd, "R8 desc_data", desc_data, m_dd);
    chk(irq == (m_stat && m_ie), "R10 irq", irq, m_stat && m_ie);
    if (mem_req) reqs++;
  end

  // memory responder
  always @(negedge clk) begin
    mem_rvalid = 0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin mem_rvalid = 1; mem_rdata = paddr ^ 32'h5A5A0F0F; end
    end
    if (mem_req) begin cnt = lat; paddr = mem_addr; end
  end

  task automatic wr(input logic [11:0] a, input int d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, input int exp, input string tag);
    @(negedge clk); reg_addr = a; #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic idle(input int n); repeat (n) @(negedge clk); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!mem_req && !desc_valid && !irq, "R1 outputs", {mem_req, desc_valid, irq}, 0);
    rd(12'h810, 0, "R1 read pointer");
    rd(12'h044, 0, "R1 status");
    // program ring: base 0x00021000, end 0xC, four entries
    wr(12'h800, 32'h1000); wr(12'h804, 32'h0002); wr(12'h808, 32'hC);
    wr(12'h048, 1); wr(12'h80C, 8);
    rd(12'h800, 32'h1000, "R11 base low");
    rd(12'h804, 32'h0002, "R11 base high");
    rd(12'h808, 32'hC, "R11 end");
    rd(12'h80C, 8, "R11 write pointer");
    idle(10);
    chk(reqs == 0, "R2 no fetch while disabled", reqs, 0);
    wr(12'h040, 1); idle(30);
    chk(reqs == 2, "R3 stop at write pointer", reqs, 2);
    rd(12'h810, 8, "R6 read pointer steps");
    rd(12'h044, 1, "R9 status set");
    chk(irq == 1, "R10 irq asserted", irq, 1);
    wr(12'h044, 1);
    rd(12'h044, 0, "R9 write-one clears");
    chk(irq == 0, "R10 irq drops", irq, 0);
    // wrap past end
    wr(12'h80C, 0); idle(30);
    chk(reqs == 4, "R7 fetch count", reqs, 4);
    rd(12'h810, 0, "R7 wrap to zero");
    // stepped value equal to end does not wrap
    wr(12'h808, 32'h10); wr(12'h80C, 32'h10); idle(40);
    rd(12'h810, 32'h10, "R7 equal to end kept");
    chk(reqs == 8, "R7 fetch count equal", reqs, 8);
    // long latency
    lat = 6; wr(12'h80C, 0); idle(30);
    rd(12'h810, 0, "R5 long latency wrap");
    chk(reqs == 9, "R5 one fetch", reqs, 9);
    // irq gating and write-zero
    wr(12'h048, 0);
    chk(irq == 0, "R10 masked", irq, 0);
    wr(12'h044, 0);
    rd(12'h044, 1, "R9 write zero ignored");
    // disable while outstanding
    lat = 8; wr(12'h80C, 8);
    while (reqs < 10) @(negedge clk);
    wr(12'h040, 0); idle(30);
    chk(reqs == 10, "R2 disable stops new fetch", reqs, 10);
    rd(12'h810, 4, "R2 outstanding fetch completed");
    fin = 1;
  end

  initial begin
    fork
      wait (fin);
      begin #400000; total++; bad++; $display("FAIL watchdog expired"); end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule